// File: doc/BRIEF.md
# Bus Width Cycle Splitter

This block sits on the host side between a processor request port and a 16-bit shared bus with a bidirectional data path. The bidirectional data path appears here as separate write and read vectors. The block takes one request at a time: an address, a read or write direction, a word or byte size and a memory or I/O space flag. It then runs the matching bus cycles. It decides at run time how to move the data. The addressed target claims 16-bit width through an active-low size line. There is one size line for memory space and one for I/O space. The block samples the line that matches the request's space once, in the first clock of the cycle.

A word sent to a 16-bit target goes out as one word cycle with both byte lanes active. A word sent to a narrow target becomes two byte cycles, both on the low byte lane. The first byte cycle uses the even address and carries the low byte. The second uses the odd address and carries the high byte. For a split read, the block holds the first byte and joins it to the second byte before it reports completion. Byte requests are steered to the lane the target can use. The active-low high-byte enable is driven to match the lanes in use. The processor side sees a busy flag and a single completion pulse with the read result.

Top module: `bus_width_splitter`

## Requirements
- R1: After reset, bus_cyc, req_busy and resp_done are 0, bus_hi_en_n is 1 and resp_rdata is 0.
- R2: A request presented with req_valid=1 while req_busy=0 starts a bus cycle on the next clock, with bus_cyc=1 and req_busy=1. In that first (probe) clock bus_addr is the request address. For word requests bit 0 of bus_addr is forced to 0.
- R3: The size decision is made from the value sampled during the probe clock only. bus_size16_io_n is used when req_io=1 and bus_size16_mem_n otherwise, and 0 means the target is 16-bit. Any change of the size lines after the probe clock has no effect on the sequence.
- R4: A word request to a 16-bit target runs one cycle with bus_hi_en_n=0 and bus_wdata equal to the full write word (bus_wdata is 0 on reads). A read returns bus_rdata[15:0] unchanged.
- R5: A word request to an 8-bit target runs two byte cycles with bus_hi_en_n=1 on both. The first uses the even address with the low write byte on bus_wdata[7:0]. The second uses the even address plus one with the high write byte on bus_wdata[7:0]. bus_wdata[15:8] is 0 in both. bus_cyc is 0 for exactly one clock between the two cycles.
- R6: For a split read, resp_rdata[7:0] is the bus_rdata[7:0] taken at the first bus_done and resp_rdata[15:8] is the bus_rdata[7:0] taken at the second bus_done.
- R7: Byte requests: an even-address byte uses bus_wdata[7:0] with bus_hi_en_n=1 for either target width. An odd-address byte to a 16-bit target uses bus_wdata[15:8] (low half 0) with bus_hi_en_n=0 and reads bus_rdata[15:8]. An odd-address byte to an 8-bit target uses bus_wdata[7:0] with bus_hi_en_n=1 and reads bus_rdata[7:0]. In every case the byte returns in resp_rdata[7:0] with resp_rdata[15:8]=0.
- R8: req_busy stays 1 from the clock after acceptance until the clock in which resp_done is 1, where it is 0. Requests presented while req_busy=1 are ignored and start no bus cycle.
- R9: resp_done is a single-clock pulse in the clock after the final bus_done. While bus_done is 0 in a data clock, bus_addr, bus_hi_en_n and bus_wdata stay unchanged.
- R10: In the probe clock bus_hi_en_n is 0 for word requests and for odd-address byte requests, and 1 for even-address byte requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit transfer, 0 = byte |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_wdata | input | 16 | Write data (byte requests use bits 7:0) |
| req_busy | output | 1 | Sequence in progress; requests ignored |
| bus_size16_mem_n | input | 1 | Active-low 16-bit claim for memory cycles |
| bus_size16_io_n | input | 1 | Active-low 16-bit claim for I/O cycles |
| bus_cyc | output | 1 | Bus cycle active |
| bus_addr | output | ADDR_W | Bus address |
| bus_write | output | 1 | Direction of the current cycle |
| bus_io | output | 1 | Space of the current cycle |
| bus_hi_en_n | output | 1 | Active-low high-byte lane enable |
| bus_wdata | output | 16 | Byte-lane write data |
| bus_rdata | input | 16 | Byte-lane read data |
| bus_done | input | 1 | Current bus cycle completes this clock |
| resp_done | output | 1 | Single-clock completion pulse |
| resp_rdata | output | 16 | Assembled read data |

## Verification
The assertions watch, on every cycle, the relations between the port signals. The high-byte enable is never active outside a bus cycle and a bus cycle always shows busy. The completion pulse lasts one clock and busy falls only together with it. The address holds while a cycle waits for its done. What the bench's scenarios alone can show is the data path. This covers the lane chosen for each width and parity of the target, the even and odd addresses of a split pair, and the order in which two read bytes are joined. It also covers the choice between the memory and I/O size lines, the immunity to late size changes, and the dropping of requests made while busy.

// File: rtl/bws_pkg.sv
package bws_pkg;

    localparam int BYTE_W = 8;
    localparam int BUS_W  = 2 * BYTE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROBE,
        ST_DATA1,
        ST_GAP,
        ST_DATA2
    } bws_state_e;

    typedef struct packed {
        logic write;
        logic word;
        logic io;
        logic odd;
    } req_attr_t;

    typedef struct packed {
        logic             hi_en_n;
        logic [BUS_W-1:0] data;
    } lane_drive_t;

    // pick the size line belonging to the request's address space
    function automatic logic sel_size_n(input logic io, input logic mem_n,
                                        input logic io_n);
        return io ? io_n : mem_n;
    endfunction

    // true when the request uses the upper lane on a wide target
    function automatic logic wants_high(input req_attr_t a);
        return a.word | a.odd;
    endfunction

    // lane drive for one bus clock
    function automatic lane_drive_t steer(input bws_state_e st,
                                          input req_attr_t a,
                                          input logic wide,
                                          input logic [BUS_W-1:0] wd);
        lane_drive_t d;
        logic        eff_wide;
        d.hi_en_n = 1'b1;
        d.data    = '0;
        eff_wide  = (st == ST_PROBE) ? 1'b1 : wide;
        unique case (st)
            ST_PROBE, ST_DATA1: begin
                if (a.word) begin
                    if (eff_wide) begin
                        d.hi_en_n = 1'b0;
                        d.data    = wd;
                    end else begin
                        d.data = {{BYTE_W{1'b0}}, wd[BYTE_W-1:0]};
                    end
                end else if (a.odd && eff_wide) begin
                    d.hi_en_n = 1'b0;
                    d.data    = {wd[BYTE_W-1:0], {BYTE_W{1'b0}}};
                end else begin
                    d.data = {{BYTE_W{1'b0}}, wd[BYTE_W-1:0]};
                end
            end
            ST_DATA2: begin
                d.data = {{BYTE_W{1'b0}}, wd[BUS_W-1:BYTE_W]};
            end
            default: begin
                d.hi_en_n = 1'b1;
                d.data    = '0;
            end
        endcase
        if (!a.write) d.data = '0;
        return d;
    endfunction

    // read result of a single (non-split) cycle
    function automatic logic [BUS_W-1:0] single_read(input req_attr_t a,
                                                     input logic wide,
                                                     input logic [BUS_W-1:0] rd);
        if (a.word)
            return rd;
        else if (a.odd && wide)
            return {{BYTE_W{1'b0}}, rd[BUS_W-1:BYTE_W]};
        else
            return {{BYTE_W{1'b0}}, rd[BYTE_W-1:0]};
    endfunction

endpackage

// File: rtl/bws_ctrl.sv
module bws_ctrl
    import bws_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                req_write,
    input  logic                req_word,
    input  logic                req_io,
    input  logic [BUS_W-1:0]    req_wdata,
    input  logic                size_mem_n,
    input  logic                size_io_n,
    input  logic                bus_done,
    output bws_state_e          state,
    output req_attr_t           attr,
    output logic                wide,
    output logic [ADDR_W-1:0]   cyc_addr,
    output logic [BUS_W-1:0]    wdata_q,
    output logic                first_done,
    output logic                fin
);

    logic [ADDR_W-1:0] base_q;
    logic              split;

    assign split      = attr.word & ~wide;
    assign first_done = (state == ST_DATA1) && bus_done && split;
    assign fin        = bus_done &&
                        (((state == ST_DATA1) && !split) || (state == ST_DATA2));
    assign cyc_addr   = (state == ST_DATA2) ? {base_q[ADDR_W-1:1], 1'b1} : base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            attr    <= '0;
            wide    <= 1'b0;
            base_q  <= '0;
            wdata_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        state      <= ST_PROBE;
                        attr.write <= req_write;
                        attr.word  <= req_word;
                        attr.io    <= req_io;
                        attr.odd   <= req_addr[0] & ~req_word;
                        base_q     <= req_word ? {req_addr[ADDR_W-1:1], 1'b0}
                                               : req_addr;
                        wdata_q    <= req_wdata;
                    end
                end
                ST_PROBE: begin
                    wide  <= ~sel_size_n(attr.io, size_mem_n, size_io_n);
                    state <= ST_DATA1;
                end
                ST_DATA1: begin
                    if (bus_done) state <= split ? ST_GAP : ST_IDLE;
                end
                ST_GAP: begin
                    state <= ST_DATA2;
                end
                ST_DATA2: begin
                    if (bus_done) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/bws_lane_steer.sv
module bws_lane_steer
    import bws_pkg::*;
(
    input  bws_state_e          state,
    input  req_attr_t           attr,
    input  logic                wide,
    input  logic [BUS_W-1:0]    wdata_q,
    output logic                hi_en_n,
    output logic [BUS_W-1:0]    lane_wdata
);

    lane_drive_t drv;

    always_comb begin
        drv        = steer(state, attr, wide, wdata_q);
        hi_en_n    = drv.hi_en_n;
        lane_wdata = drv.data;
    end

endmodule

// File: rtl/bws_read_assemble.sv
module bws_read_assemble
    import bws_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  req_attr_t           attr,
    input  logic                wide,
    input  logic                in_second,
    input  logic                first_done,
    input  logic                fin,
    input  logic [BUS_W-1:0]    bus_rdata,
    output logic                resp_done,
    output logic [BUS_W-1:0]    resp_rdata
);

    logic [BYTE_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q     <= '0;
            resp_done  <= 1'b0;
            resp_rdata <= '0;
        end else begin
            resp_done <= fin;
            if (first_done) hold_q <= bus_rdata[BYTE_W-1:0];
            if (fin) begin
                if (in_second)
                    resp_rdata <= {bus_rdata[BYTE_W-1:0], hold_q};
                else
                    resp_rdata <= single_read(attr, wide, bus_rdata);
            end
        end
    end

endmodule

// File: rtl/bus_width_splitter.sv
module bus_width_splitter
    import bws_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                req_write,
    input  logic                req_word,
    input  logic                req_io,
    input  logic [15:0]         req_wdata,
    output logic                req_busy,
    input  logic                bus_size16_mem_n,
    input  logic                bus_size16_io_n,
    output logic                bus_cyc,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic                bus_write,
    output logic                bus_io,
    output logic                bus_hi_en_n,
    output logic [15:0]         bus_wdata,
    input  logic [15:0]         bus_rdata,
    input  logic                bus_done,
    output logic                resp_done,
    output logic [15:0]         resp_rdata
);

    bws_state_e        state;
    req_attr_t         attr;
    logic              wide;
    logic [BUS_W-1:0]  wdata_q;
    logic              first_done;
    logic              fin;

    bws_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid & ~req_busy),
        .req_addr   (req_addr),
        .req_write  (req_write),
        .req_word   (req_word),
        .req_io     (req_io),
        .req_wdata  (req_wdata),
        .size_mem_n (bus_size16_mem_n),
        .size_io_n  (bus_size16_io_n),
        .bus_done   (bus_done),
        .state      (state),
        .attr       (attr),
        .wide       (wide),
        .cyc_addr   (bus_addr),
        .wdata_q    (wdata_q),
        .first_done (first_done),
        .fin        (fin)
    );

    bws_lane_steer steer_i (
        .state      (state),
        .attr       (attr),
        .wide       (wide),
        .wdata_q    (wdata_q),
        .hi_en_n    (bus_hi_en_n),
        .lane_wdata (bus_wdata)
    );

    bws_read_assemble asm_i (
        .clk        (clk),
        .rst        (rst),
        .attr       (attr),
        .wide       (wide),
        .in_second  (state == ST_DATA2),
        .first_done (first_done),
        .fin        (fin),
        .bus_rdata  (bus_rdata),
        .resp_done  (resp_done),
        .resp_rdata (resp_rdata)
    );

    assign req_busy  = (state != ST_IDLE);
    assign bus_cyc   = (state == ST_PROBE) || (state == ST_DATA1) ||
                       (state == ST_DATA2);
    assign bus_write = attr.write;
    assign bus_io    = attr.io;

endmodule

// File: rtl/bws_checker.sv
module bws_checker #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              req_busy,
    input logic              bus_cyc,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_hi_en_n,
    input logic              bus_done,
    input logic              resp_done
);

    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!bus_cyc && !req_busy && !resp_done && bus_hi_en_n));

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        resp_done |=> !resp_done);

    a_r8_free_at_done: assert property (@(posedge clk) disable iff (rst)
        resp_done |-> !req_busy);

    a_r8_fall_with_done: assert property (@(posedge clk) disable iff (rst)
        $fell(req_busy) |-> resp_done);

    a_r2_cyc_busy: assert property (@(posedge clk) disable iff (rst)
        bus_cyc |-> req_busy);

    a_r5_hi_only_in_cycle: assert property (@(posedge clk) disable iff (rst)
        !bus_hi_en_n |-> bus_cyc);

    a_r9_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (bus_cyc && !bus_done) |=> (!bus_cyc || $stable(bus_addr)));

endmodule

bind bus_width_splitter bws_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .req_busy    (req_busy),
    .bus_cyc     (bus_cyc),
    .bus_addr    (bus_addr),
    .bus_hi_en_n (bus_hi_en_n),
    .bus_done    (bus_done),
    .resp_done   (resp_done)
);

// File: tb/bus_width_splitter_tb_top.sv
`timescale 1ns/1ps
module bus_width_splitter_tb_top;

    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid, req_write, req_word, req_io;
    logic [AW-1:0] req_addr;
    logic [15:0]   req_wdata;
    logic          req_busy;
    logic          mem_n, io_n;
    logic          bus_cyc, bus_write, bus_io, bus_hi_en_n;
    logic [AW-1:0] bus_addr;
    logic [15:0]   bus_wdata, bus_rdata;
    logic          bus_done;
    logic          resp_done;
    logic [15:0]   resp_rdata;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    bus_width_splitter #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .req_word(req_word), .req_io(req_io), .req_wdata(req_wdata),
        .req_busy(req_busy),
        .bus_size16_mem_n(mem_n), .bus_size16_io_n(io_n),
        .bus_cyc(bus_cyc), .bus_addr(bus_addr), .bus_write(bus_write),
        .bus_io(bus_io), .bus_hi_en_n(bus_hi_en_n), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_done(bus_done),
        .resp_done(resp_done), .resp_rdata(resp_rdata)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic issue(input logic [AW-1:0] a, input logic wr,
                         input logic wd, input logic io, input logic [15:0] d);
        req_addr  = a; req_write = wr; req_word = wd; req_io = io;
        req_wdata = d; req_valid = 1'b1;
        step();
        req_valid = 1'b0;
    endtask

    task automatic ack(input logic [15:0] rd);
        bus_done  = 1'b1;
        bus_rdata = rd;
        step();
        bus_done  = 1'b0;
        bus_rdata = 16'h0000;
    endtask

    task automatic finish_check(input string tag, input logic [15:0] exp_rd,
                                input bit check_rd);
        chk(resp_done === 1'b1, {tag, " resp_done"}, resp_done, 1);
        chk(req_busy === 1'b0, {tag, " busy low at done"}, req_busy, 0);
        if (check_rd) chk(resp_rdata === exp_rd, {tag, " rdata"}, resp_rdata, exp_rd);
        step();
        chk(resp_done === 1'b0, {tag, " pulse single"}, resp_done, 0);
    endtask

    task automatic t_reset();
        chk(bus_cyc === 0 && req_busy === 0 && resp_done === 0 && bus_hi_en_n === 1,
            "R1 idle outputs", {bus_cyc, req_busy, resp_done, bus_hi_en_n}, 4'b0001);
        chk(resp_rdata === 16'h0, "R1 rdata", resp_rdata, 0);
    endtask

    task automatic t_word16_write();
        mem_n = 0; io_n = 1;
        issue(24'h001235, 1, 1, 0, 16'hBEEF);
        chk(bus_cyc === 1 && req_busy === 1, "R2 start", {bus_cyc, req_busy}, 2'b11);
        chk(bus_addr === 24'h001234, "R2 word even addr", bus_addr, 24'h001234);
        chk(bus_hi_en_n === 0, "R10 probe hi word", bus_hi_en_n, 0);
        step();
        chk(bus_hi_en_n === 0, "R4 hi enable", bus_hi_en_n, 0);
        chk(bus_wdata === 16'hBEEF, "R4 wdata", bus_wdata, 16'hBEEF);
        step();
        chk(bus_addr === 24'h001234 && bus_wdata === 16'hBEEF, "R9 hold in wait",
            bus_wdata, 16'hBEEF);
        ack(16'h0);
        finish_check("R4 word16 write", 16'h0, 0);
    endtask

    task automatic t_word16_io_read();
        mem_n = 1; io_n = 0;
        issue(24'h000300, 0, 1, 1, 16'h0);
        chk(bus_io === 1 && bus_write === 0, "R2 io read attrs", {bus_io, bus_write}, 2'b10);
        step();
        chk(bus_hi_en_n === 0, "R3 io line selects wide", bus_hi_en_n, 0);
        chk(bus_wdata === 16'h0, "R4 read lanes zero", bus_wdata, 0);
        ack(16'hA55A);
        finish_check("R4 word16 read", 16'hA55A, 1);
    endtask

    task automatic t_split_read_late_size();
        mem_n = 1; io_n = 0;
        issue(24'h0A0010, 0, 1, 0, 16'h0);
        chk(bus_hi_en_n === 0, "R10 probe hi split word", bus_hi_en_n, 0);
        step();
        mem_n = 0;
        chk(bus_addr === 24'h0A0010 && bus_hi_en_n === 1, "R5 first byte cycle",
            {bus_addr, 7'b0, bus_hi_en_n}, {24'h0A0010, 8'h01});
        step();
        step();
        chk(bus_cyc === 1 && bus_hi_en_n === 1, "R3 late size ignored", bus_hi_en_n, 1);
        ack(16'hFF5A);
        chk(bus_cyc === 0 && req_busy === 1 && resp_done === 0, "R5 gap clock",
            {bus_cyc, req_busy, resp_done}, 3'b010);
        step();
        chk(bus_cyc === 1 && bus_addr === 24'h0A0011 && bus_hi_en_n === 1,
            "R5 second byte cycle", bus_addr, 24'h0A0011);
        ack(16'h77C3);
        finish_check("R6 split read", 16'hC35A, 1);
        mem_n = 1;
    endtask

    task automatic t_split_io_write_busy();
        mem_n = 0; io_n = 1;
        issue(24'h0002F8, 1, 1, 1, 16'h1234);
        step();
        req_addr = 24'h000055; req_word = 0; req_valid = 1;
        chk(bus_wdata === 16'h0034 && bus_hi_en_n === 1, "R5 io split low byte",
            bus_wdata, 16'h0034);
        ack(16'h0);
        chk(bus_cyc === 0, "R5 gap", bus_cyc, 0);
        step();
        chk(bus_wdata === 16'h0012 && bus_addr === 24'h0002F9,
            "R5 high byte on low lane", bus_wdata, 16'h0012);
        chk(req_busy === 1, "R8 busy during split", req_busy, 1);
        req_valid = 0;
        ack(16'h0);
        finish_check("R8 split write", 16'h0, 0);
        chk(bus_cyc === 0 && req_busy === 0, "R8 ignored request", {bus_cyc, req_busy}, 0);
        io_n = 1;
    endtask

    task automatic t_bytes();
        mem_n = 0;
        issue(24'h000100, 1, 0, 0, 16'hEE42);
        chk(bus_hi_en_n === 1, "R10 probe even byte", bus_hi_en_n, 1);
        step();
        chk(bus_wdata === 16'h0042 && bus_hi_en_n === 1, "R7 even byte", bus_wdata, 16'h0042);
        ack(16'h0);
        finish_check("R7 even byte", 16'h0, 0);
        issue(24'h000101, 0, 0, 0, 16'h0);
        chk(bus_addr === 24'h000101 && bus_hi_en_n === 0, "R10 probe odd byte",
            bus_addr, 24'h000101);
        step();
        chk(bus_hi_en_n === 0, "R7 odd byte wide hi", bus_hi_en_n, 0);
        ack(16'h9C11);
        finish_check("R7 odd byte wide read", 16'h009C, 1);
        issue(24'h000103, 1, 0, 0, 16'h0081);
        step();
        chk(bus_wdata === 16'h8100, "R7 odd byte wide lane", bus_wdata, 16'h8100);
        ack(16'h0);
        finish_check("R7 odd wide write", 16'h0, 0);
        mem_n = 1;
        issue(24'h000107, 1, 0, 0, 16'h00D7);
        step();
        chk(bus_wdata === 16'h00D7 && bus_hi_en_n === 1, "R7 odd byte narrow write",
            bus_wdata, 16'h00D7);
        ack(16'h0);
        finish_check("R7 odd narrow write", 16'h0, 0);
        issue(24'h000109, 0, 0, 0, 16'h0);
        step();
        ack(16'h9C11);
        finish_check("R7 odd narrow read", 16'h0011, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; req_valid = 0; req_addr = '0; req_write = 0; req_word = 0;
        req_io = 0; req_wdata = '0; mem_n = 1; io_n = 1; bus_done = 0;
        bus_rdata = '0;
        repeat (3) step();
        rst = 0;
        step();
        t_reset();
        t_word16_write();
        t_word16_io_read();
        t_split_read_late_size();
        t_split_io_write_busy();
        t_bytes();
        step();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule